// File: doc/BRIEF.md
# Data Access Address Translator

This unit turns one data load or store request into either a physical address or a fault. A request carries a virtual address, an access size, a store flag, a physical-mode flag, an alternate-mode flag and a flag that marks a page-table-entry fetch. Alongside it the unit receives the current privilege mode, an alternate mode, a flag saying that privileged code is running, and the result of a TLB lookup made elsewhere on the same virtual address.

The checks run in a fixed priority. Alignment comes first, then physical pass-through, then virtual-address range, then a directly mapped kernel window, then TLB miss and per-mode permission. A machine-check test on the resulting physical address follows, and finally uncacheable space is classified. The outcome is registered and presented one cycle after the request strobe. It has four parts: a fault code, a six-bit status flag vector, a 44-bit physical address and an uncacheable flag.

A two-state controller paces the reply. ST_IDLE moves to ST_REPLY when `req_valid` is high. ST_REPLY stays in ST_REPLY on a back-to-back request and returns to ST_IDLE otherwise. `rsp_valid` is high exactly in ST_REPLY.

Top module: `xlat_data_unit`

## Requirements
- R1: `rsp_valid` is high in the cycle after each cycle with `req_valid` high and low otherwise. After reset every output is zero. Whenever the fault code is not zero, `rsp_paddr` and `rsp_uncached` are zero.
- R2: An access is misaligned when (vaddr AND (size-1)) is nonzero. It reports fault code 1 (alignment) ahead of every other check. The flags carry only bit 0 (write), and only for a store.
- R3: With `priv_code` high, permission uses `alt_mode` when `req_alt` is set and kernel mode (0) otherwise. With `priv_code` low it uses `cur_mode`. Modes: 0 kernel, 1 executive, 2 supervisor, 3 user.
- R4: A physical-mode request takes the virtual address unchanged as its physical address.
- R5: A virtual address whose bits 63:48 differ from bit 47 gives fault code 3 (page fault). Its flags are bit 2 (bad address) and bit 1 (access violation), plus bit 0 for a store.
- R6: Addresses with bits 47:41 equal to 0x7E are directly mapped and legal only when `cur_mode` is kernel. The check uses `cur_mode` even when an effective mode applies. Otherwise the request gives fault code 2 (access violation) with flag bit 1, plus bit 0 for a store.
- R7: A legal directly mapped address is the virtual address masked to 44 bits. If bit 40 of the result is set, bits 43:40 become ones. Otherwise all bits above 39 are cleared.
- R8: A TLB miss gives fault code 4 for a page-table-entry fetch and 5 otherwise. Its flags are bit 3 (miss), plus bit 0 for a store.
- R9: On a permitted TLB hit the physical address is {ppn, vaddr[12:0]}.
- R10: A store whose write-enable bit at the effective mode is clear gives fault code 3 with flags bits 0 and 1, plus bit 5 if fault-on-write is set. A permitted store with fault-on-write set gives fault code 3 with flags bits 0 and 5 only.
- R11: A load whose read-enable bit at the effective mode is clear gives fault code 2 with flag bit 1, plus bit 4 if fault-on-read is set. A permitted load with fault-on-read set gives fault code 3 with flag bit 4 only.
- R12: A physical address without an earlier fault that has any bit above 43 set gives fault code 6 (machine check) with all flags zero.
- R13: A physical address with bit 43 set and no fault raises `rsp_uncached` and has bits 42:35 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 64 | Virtual address |
| req_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| req_write | input | 1 | Store when high |
| req_phys | input | 1 | Physical-mode request |
| req_alt | input | 1 | Use alternate mode under privileged code |
| req_pte | input | 1 | Request is a page-table-entry fetch |
| cur_mode | input | 2 | Current privilege mode |
| alt_mode | input | 2 | Alternate privilege mode |
| priv_code | input | 1 | Privileged code is executing |
| tlb_hit | input | 1 | TLB lookup found a matching entry |
| tlb_ppn | input | 31 | Physical page number of the entry |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fo_rd | input | 1 | Entry faults on read |
| tlb_fo_wr | input | 1 | Entry faults on write |
| rsp_valid | output | 1 | Reply present |
| rsp_fault | output | 3 | Fault code: 0 none, 1 align, 2 access violation, 3 page, 4 table miss, 5 miss, 6 machine check |
| rsp_flags | output | 6 | Status: 0 write, 1 violation, 2 bad address, 3 miss, 4 fault-on-read, 5 fault-on-write |
| rsp_paddr | output | 44 | Physical address |
| rsp_uncached | output | 1 | Address lies in uncacheable space |

## Verification
Alignment is swept over every size with every low address pattern, for both loads and stores. The swept requests use physical mode, so only the alignment priority can tell a fault from a pass-through. Permission is swept across all current and alternate modes, both `priv_code` values, every one-hot enable mask and both fault-on bits. This shows whether the effective mode picks the right enable bit and whether the fault-on bits combine correctly with a denied access. The directly mapped window is tried in every current mode and with bit 40 clear and set, which separates kernel legality from sign extension and uncacheable marking. Out-of-range virtual addresses, misses with and without the table-fetch flag, and physical addresses above 43 bits cover the remaining priority steps.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_ALIGN    = 3'd1,
        FLT_ACV      = 3'd2,
        FLT_PAGE     = 3'd3,
        FLT_MISS_PTE = 3'd4,
        FLT_MISS     = 3'd5,
        FLT_MCHK     = 3'd6
    } fault_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_REPLY = 1'b1
    } rsp_state_e;

    localparam int FLAG_W   = 6;
    localparam int FB_WR    = 0;
    localparam int FB_ACV   = 1;
    localparam int FB_BADVA = 2;
    localparam int FB_MISS  = 3;
    localparam int FB_FOR   = 4;
    localparam int FB_FOW   = 5;

    localparam int          MODE_W      = 2;
    localparam int          NMODES      = 1 << MODE_W;
    localparam logic [1:0]  MODE_KERNEL = 2'd0;
endpackage

// File: rtl/xlat_mode_sel.sv
module xlat_mode_sel
    import xlat_pkg::*;
(
    input  logic              priv_code,
    input  logic              req_alt,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [MODE_W-1:0] alt_mode,
    output logic [MODE_W-1:0] eff_mode
);
    always_comb begin
        if (priv_code) begin
            eff_mode = req_alt ? alt_mode : MODE_KERNEL;
        end else begin
            eff_mode = cur_mode;
        end
    end
endmodule

// File: rtl/xlat_perm_check.sv
module xlat_perm_check
    import xlat_pkg::*;
(
    input  logic              is_write,
    input  logic [MODE_W-1:0] eff_mode,
    input  logic [NMODES-1:0] rd_en,
    input  logic [NMODES-1:0] wr_en,
    input  logic              fo_rd,
    input  logic              fo_wr,
    output fault_e            perm_fault,
    output logic [FLAG_W-1:0] perm_flags
);
    always_comb begin
        perm_fault = FLT_NONE;
        perm_flags = '0;
        if (is_write) begin
            if (!wr_en[eff_mode]) begin
                perm_fault         = FLT_PAGE;
                perm_flags[FB_WR]  = 1'b1;
                perm_flags[FB_ACV] = 1'b1;
                perm_flags[FB_FOW] = fo_wr;
            end else if (fo_wr) begin
                perm_fault         = FLT_PAGE;
                perm_flags[FB_WR]  = 1'b1;
                perm_flags[FB_FOW] = 1'b1;
            end
        end else begin
            if (!rd_en[eff_mode]) begin
                perm_fault         = FLT_ACV;
                perm_flags[FB_ACV] = 1'b1;
                perm_flags[FB_FOR] = fo_rd;
            end else if (fo_rd) begin
                perm_fault         = FLT_PAGE;
                perm_flags[FB_FOR] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xlat_phys_post.sv
module xlat_phys_post #(
    parameter int VA_W   = 64,
    parameter int PA_W   = 44,
    parameter int UNC_HI = 42,
    parameter int UNC_LO = 35
) (
    input  logic [VA_W-1:0] pa_in,
    output logic            mchk,
    output logic            uncached,
    output logic [PA_W-1:0] pa_out
);
    localparam int UNC_BIT = PA_W - 1;
    localparam int CLR_W   = UNC_HI - UNC_LO + 1;
    localparam logic [PA_W-1:0] CLR_MASK =
        PA_W'(((64'd1 << CLR_W) - 64'd1) << UNC_LO);

    always_comb begin
        mchk     = |pa_in[VA_W-1:PA_W];
        uncached = pa_in[UNC_BIT];
        pa_out   = uncached ? (pa_in[PA_W-1:0] & ~CLR_MASK) : pa_in[PA_W-1:0];
    end
endmodule

// File: rtl/xlat_data_unit.sv
module xlat_data_unit
    import xlat_pkg::*;
#(
    parameter int         VA_W       = 64,
    parameter int         PA_W       = 44,
    parameter int         PAGE_SHIFT = 13,
    parameter int         VA_IMPL    = 48,
    parameter int         SIZE_W     = 4,
    parameter int         DM_HI      = 47,
    parameter int         DM_LO      = 41,
    parameter logic [6:0] DM_TAG     = 7'h7E,
    parameter int         SIGN_BIT   = 40,
    parameter int         PPN_W      = PA_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              req_write,
    input  logic              req_phys,
    input  logic              req_alt,
    input  logic              req_pte,
    input  logic [1:0]        cur_mode,
    input  logic [1:0]        alt_mode,
    input  logic              priv_code,
    input  logic              tlb_hit,
    input  logic [PPN_W-1:0]  tlb_ppn,
    input  logic [3:0]        tlb_rd_en,
    input  logic [3:0]        tlb_wr_en,
    input  logic              tlb_fo_rd,
    input  logic              tlb_fo_wr,
    output logic              rsp_valid,
    output logic [2:0]        rsp_fault,
    output logic [5:0]        rsp_flags,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic              rsp_uncached
);
    localparam int SEXT_LSB = VA_IMPL - 1;

    rsp_state_e        state_q, state_d;
    logic [MODE_W-1:0] eff_mode;
    fault_e            perm_fault, pre_fault, nxt_fault;
    logic [FLAG_W-1:0] perm_flags, pre_flags, nxt_flags, wr_only;
    logic [VA_W-1:0]   pre_pa, dm_pa, tlb_pa;
    logic [SIZE_W-1:0] size_m1;
    logic              misaligned, bad_va, dm_sel;
    logic              post_mchk, post_unc;
    logic [PA_W-1:0]   post_pa;

    xlat_mode_sel u_mode (
        .priv_code (priv_code),
        .req_alt   (req_alt),
        .cur_mode  (cur_mode),
        .alt_mode  (alt_mode),
        .eff_mode  (eff_mode)
    );

    xlat_perm_check u_perm (
        .is_write   (req_write),
        .eff_mode   (eff_mode),
        .rd_en      (tlb_rd_en),
        .wr_en      (tlb_wr_en),
        .fo_rd      (tlb_fo_rd),
        .fo_wr      (tlb_fo_wr),
        .perm_fault (perm_fault),
        .perm_flags (perm_flags)
    );

    xlat_phys_post #(.VA_W(VA_W), .PA_W(PA_W)) u_post (
        .pa_in    (pre_pa),
        .mchk     (post_mchk),
        .uncached (post_unc),
        .pa_out   (post_pa)
    );

    // Address candidates
    always_comb begin
        size_m1    = req_size - SIZE_W'(1);
        misaligned = |(req_vaddr[SIZE_W-1:0] & size_m1);
        bad_va     = !((&req_vaddr[VA_W-1:SEXT_LSB]) || !(|req_vaddr[VA_W-1:SEXT_LSB]));
        dm_sel     = (req_vaddr[DM_HI:DM_LO] == DM_TAG);
        tlb_pa     = VA_W'({tlb_ppn, req_vaddr[PAGE_SHIFT-1:0]});
        dm_pa      = VA_W'(req_vaddr[PA_W-1:0]);
        if (dm_pa[SIGN_BIT]) begin
            dm_pa[PA_W-1:SIGN_BIT] = '1;
        end else begin
            dm_pa[VA_W-1:SIGN_BIT] = '0;
        end
        wr_only        = '0;
        wr_only[FB_WR] = req_write;
    end

    // Fixed-priority fault selection
    always_comb begin
        pre_fault = FLT_NONE;
        pre_flags = '0;
        pre_pa    = '0;
        if (misaligned) begin
            pre_fault = FLT_ALIGN;
            pre_flags = wr_only;
        end else if (req_phys) begin
            pre_pa = req_vaddr;
        end else if (bad_va) begin
            pre_fault           = FLT_PAGE;
            pre_flags           = wr_only;
            pre_flags[FB_BADVA] = 1'b1;
            pre_flags[FB_ACV]   = 1'b1;
        end else if (dm_sel) begin
            if (cur_mode != MODE_KERNEL) begin
                pre_fault         = FLT_ACV;
                pre_flags         = wr_only;
                pre_flags[FB_ACV] = 1'b1;
            end else begin
                pre_pa = dm_pa;
            end
        end else if (!tlb_hit) begin
            pre_fault          = req_pte ? FLT_MISS_PTE : FLT_MISS;
            pre_flags          = wr_only;
            pre_flags[FB_MISS] = 1'b1;
        end else begin
            pre_pa    = tlb_pa;
            pre_fault = perm_fault;
            pre_flags = perm_flags;
        end

        nxt_fault = pre_fault;
        nxt_flags = pre_flags;
        if (pre_fault == FLT_NONE && post_mchk) begin
            nxt_fault = FLT_MCHK;
            nxt_flags = '0;
        end
    end

    // Reply controller
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = req_valid ? ST_REPLY : ST_IDLE;
            ST_REPLY: state_d = req_valid ? ST_REPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_fault    <= '0;
            rsp_flags    <= '0;
            rsp_paddr    <= '0;
            rsp_uncached <= 1'b0;
        end else if (req_valid) begin
            rsp_fault    <= nxt_fault;
            rsp_flags    <= nxt_flags;
            rsp_paddr    <= (nxt_fault == FLT_NONE) ? post_pa : '0;
            rsp_uncached <= (nxt_fault == FLT_NONE) && post_unc;
        end
    end

    assign rsp_valid = (state_q == ST_REPLY);
endmodule

// File: rtl/xlat_data_chk.sv
module xlat_data_chk #(
    parameter int VA_W = 64,
    parameter int PA_W = 44
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic [3:0]      req_size,
    input logic            req_phys,
    input logic            rsp_valid,
    input logic [2:0]      rsp_fault,
    input logic [5:0]      rsp_flags,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_uncached
);
    logic aligned_now;
    assign aligned_now = ((req_vaddr[3:0] & (req_size - 4'd1)) == 4'd0);

    AST_REPLY_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1
    AST_QUIET_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R1
    AST_FAULT_CLEARS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 3'd0) |-> (rsp_paddr == '0 && !rsp_uncached)); // R1
    AST_MISALIGN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !aligned_now) |=> (rsp_fault == 3'd1)); // R2
    AST_PHYS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_phys && aligned_now && req_vaddr[VA_W-1:PA_W-1] == '0)
        |=> (rsp_fault == 3'd0 && rsp_paddr == $past(req_vaddr[PA_W-1:0]))); // R4
    AST_MISS_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault == 3'd4 || rsp_fault == 3'd5)) |-> rsp_flags[3]); // R8
    AST_MCHK_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 3'd6) |-> (rsp_flags == 6'd0)); // R12
    AST_UNCACHED_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_uncached) |-> (rsp_paddr[PA_W-1] && rsp_paddr[42:35] == 8'd0)); // R13
endmodule

bind xlat_data_unit xlat_data_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_vaddr    (req_vaddr),
    .req_size     (req_size),
    .req_phys     (req_phys),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .rsp_flags    (rsp_flags),
    .rsp_paddr    (rsp_paddr),
    .rsp_uncached (rsp_uncached)
);

// File: tb/sim_xlat_data_unit.sv
module sim_xlat_data_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] b_va = '0;
    logic [3:0]  b_size = 4'd1;
    logic        b_wr = 0, b_phys = 0, b_alt = 0, b_pte = 0, b_priv = 0, b_hit = 0;
    logic [1:0]  b_cur = 0, b_altm = 0;
    logic [30:0] b_ppn = '0;
    logic [3:0]  b_rd = '0, b_wren = '0;
    logic        b_for = 0, b_fow = 0;
    logic        rsp_valid, rsp_uncached;
    logic [2:0]  rsp_fault;
    logic [5:0]  rsp_flags;
    logic [43:0] rsp_paddr;
    int          n_checks = 0;
    int          n_fails = 0;
    bit          finished = 0;

    always #2 clk = ~clk;

    xlat_data_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(b_va),
        .req_size(b_size), .req_write(b_wr), .req_phys(b_phys), .req_alt(b_alt),
        .req_pte(b_pte), .cur_mode(b_cur), .alt_mode(b_altm), .priv_code(b_priv),
        .tlb_hit(b_hit), .tlb_ppn(b_ppn), .tlb_rd_en(b_rd), .tlb_wr_en(b_wren),
        .tlb_fo_rd(b_for), .tlb_fo_wr(b_fow), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_flags(rsp_flags), .rsp_paddr(rsp_paddr),
        .rsp_uncached(rsp_uncached)
    );

    task automatic model(output logic [2:0] f, output logic [5:0] fl,
                         output logic [43:0] pa, output logic unc, output string tag);
        logic [63:0] p;
        logic [1:0]  em;
        logic [5:0]  w;
        f = 0; fl = 0; p = 0; unc = 0; tag = "";
        w  = {5'b0, b_wr};
        em = b_priv ? (b_alt ? b_altm : 2'd0) : b_cur;
        if ((b_va[3:0] & (b_size - 4'd1)) != 4'd0) begin
            f = 1; fl = w; tag = "R2";
        end else if (b_phys) begin
            p = b_va; tag = "R4";
        end else if (!(b_va[63:47] == 17'h0 || b_va[63:47] == 17'h1FFFF)) begin
            f = 3; fl = 6'b000110 | w; tag = "R5";
        end else if (b_va[47:41] == 7'h7E) begin
            if (b_cur != 2'd0) begin
                f = 2; fl = 6'b000010 | w; tag = "R6";
            end else begin
                p = b_va & 64'h0000_0FFF_FFFF_FFFF;
                if (p[40]) p[43:40] = 4'hF;
                else p[63:40] = '0;
                tag = "R7";
            end
        end else if (!b_hit) begin
            f = b_pte ? 3'd4 : 3'd5; fl = 6'b001000 | w; tag = "R8";
        end else begin
            p = {20'b0, b_ppn, b_va[12:0]};
            tag = b_priv ? "R3" : "R9";
            if (b_wr) begin
                if (!b_wren[em]) begin
                    f = 3; fl = 6'b000011 | (b_fow ? 6'b100000 : 6'b0); tag = "R10";
                end else if (b_fow) begin
                    f = 3; fl = 6'b100001; tag = "R10";
                end
            end else begin
                if (!b_rd[em]) begin
                    f = 2; fl = 6'b000010 | (b_for ? 6'b010000 : 6'b0); tag = "R11";
                end else if (b_for) begin
                    f = 3; fl = 6'b010000; tag = "R11";
                end
            end
        end
        if (f == 0) begin
            if (p[63:44] != 20'd0) begin
                f = 6; fl = 0; tag = {tag, "/R12"};
            end else if (p[43]) begin
                unc = 1; p[42:35] = 8'd0; tag = {tag, "/R13"};
            end
        end
        pa = (f == 0) ? p[43:0] : 44'd0;
        if (f != 0) unc = 0;
    endtask

    task automatic issue_and_check();
        logic [2:0]  ef;
        logic [5:0]  efl;
        logic [43:0] epa;
        logic        eu;
        string       tag;
        @(negedge clk);
        req_valid = 1'b1;
        model(ef, efl, epa, eu, tag);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        n_checks++;
        if (!rsp_valid || rsp_fault !== ef || rsp_flags !== efl ||
            rsp_paddr !== epa || rsp_uncached !== eu) begin
            n_fails++;
            $display("FAIL %s va=%h: got v=%b f=%0d fl=%b pa=%h u=%b, expected v=1 f=%0d fl=%b pa=%h u=%b",
                     tag, b_va, rsp_valid, rsp_fault, rsp_flags, rsp_paddr, rsp_uncached,
                     ef, efl, epa, eu);
        end
    endtask

    task automatic clear_req();
        b_wr = 0; b_phys = 0; b_alt = 0; b_pte = 0; b_priv = 0; b_hit = 0;
        b_cur = 0; b_altm = 0; b_ppn = '0; b_rd = '0; b_wren = '0;
        b_for = 0; b_fow = 0; b_size = 4'd8;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_checks++;
        if (rsp_valid !== 0 || rsp_fault !== 0 || rsp_flags !== 0 ||
            rsp_paddr !== 0 || rsp_uncached !== 0) begin
            n_fails++;
            $display("FAIL R1 reset: got v=%b f=%0d fl=%b pa=%h, expected all zero",
                     rsp_valid, rsp_fault, rsp_flags, rsp_paddr);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2: every size with every low address pattern
        for (int s = 0; s < 4; s++) begin
            for (int lo = 0; lo < 8; lo++) begin
                for (int w = 0; w < 2; w++) begin
                    clear_req();
                    b_phys = 1; b_size = 4'(1 << s); b_wr = w[0];
                    b_va = 64'h0000_0000_0001_2340 | 64'(lo);
                    issue_and_check();
                end
            end
        end

        // R1: idle cycle gives no reply
        @(negedge clk);
        @(posedge clk);
        #1;
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R1 idle: got v=%b, expected v=0", rsp_valid);
        end

        // R3, R9, R10, R11, R13: mode and permission sweep on TLB hits
        for (int pv = 0; pv < 2; pv++)
        for (int al = 0; al < 2; al++)
        for (int cm = 0; cm < 4; cm++)
        for (int am = 0; am < 4; am++)
        for (int w = 0; w < 2; w++)
        for (int k = 0; k < 4; k++)
        for (int fo = 0; fo < 2; fo++) begin
            clear_req();
            b_hit = 1; b_priv = pv[0]; b_alt = al[0]; b_cur = 2'(cm); b_altm = 2'(am);
            b_wr = w[0]; b_rd = 4'(1 << k); b_wren = 4'(1 << k);
            b_for = fo[0]; b_fow = fo[0];
            b_ppn = k[0] ? 31'h4000_01FF : 31'h0001_2345;
            b_va = 64'hFFFF_8000_0000_2000 | 64'(k * 8 + 16'h1AB8);
            issue_and_check();
        end

        // R6, R7, R13: directly mapped window
        for (int cm = 0; cm < 4; cm++)
        for (int b40 = 0; b40 < 2; b40++)
        for (int w = 0; w < 2; w++) begin
            clear_req();
            b_cur = 2'(cm); b_wr = w[0]; b_priv = 1;
            b_va = 64'hFFFF_FC00_0000_0000 | (64'(b40) << 40) | 64'h0000_0087_6543_2108;
            issue_and_check();
        end

        // R8: misses
        for (int pt = 0; pt < 2; pt++)
        for (int w = 0; w < 2; w++) begin
            clear_req();
            b_pte = pt[0]; b_wr = w[0];
            b_va = 64'h0000_0000_4000_0010;
            issue_and_check();
        end

        // R5: out-of-range virtual addresses
        for (int i = 0; i < 3; i++)
        for (int w = 0; w < 2; w++) begin
            clear_req();
            b_wr = w[0]; b_hit = 1; b_rd = 4'hF; b_wren = 4'hF;
            b_va = (i == 0) ? 64'h0001_0000_0000_0000 :
                   (i == 1) ? 64'h8000_0000_0000_0000 : 64'hFFFF_0000_0000_0000;
            issue_and_check();
        end

        // R4, R12, R13: physical mode
        for (int i = 0; i < 3; i++) begin
            clear_req();
            b_phys = 1;
            b_va = (i == 0) ? 64'h0000_1000_0000_0000 :
                   (i == 1) ? 64'h0000_0FF8_1FFF_F008 : 64'h0000_0123_4567_89A8;
            issue_and_check();
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule